// File: doc/BRIEF.md
# Configurable Serial Audio Transmitter

This block turns pairs of 16-bit audio samples into a three-wire serial audio stream: a bit clock, a word select line that tells which channel is on the wire, and a serial data line. Samples arrive as a left/right pair over a valid/ready handshake. One pair waits in a buffer while the previous pair is shifted out. The block takes the next pair at the start of each frame.

A set of static configuration inputs chooses how the frame looks. The frame alignment can be I2S, left-justified or right-justified. The other inputs choose which end of the word goes out first, which word-select level means left, and the bit clock polarity. In right-justified slots, the spare high bits can be filled with zeros or with copies of the sign bit. The channel mode selects stereo, mono from one channel, or mute. A channel slot is `SLOT_BITS` bit clocks wide and may be longer than the 16-bit sample. Each bit clock lasts `2*CLK_DIV` cycles of the system clock.

Software sets the configuration inputs and raises `out_en`, then pulses `start`. The configuration is captured at that pulse. Dropping `out_en` stops the stream.

Top module: `audio_ser_tx`

## Requirements
- R1: After synchronous reset, `bclk`, `ws` and `sdo` are low and `s_ready` is high.
- R2: `start` has no effect while `out_en` is low. Taking `out_en` low while running stops the stream: `sdo` goes to 0 and `bclk` holds its idle level with no further edges.
- R3: While running, one bit clock period is `2*CLK_DIV` system clocks. `ws` and `sdo` change only when `bclk` takes its inactive level, so a receiver samples them on the active edge.
- R4: With `cfg_ws_left_high`=0, `ws` is low for the left slot and high for the right slot. With 1, the levels are swapped.
- R5: With `cfg_align`=0 (I2S), the first data bit of a slot appears one bit clock after the `ws` change. Bit positions after the 16 data bits are 0.
- R6: With `cfg_align`=1 (left-justified), the first data bit appears in the same bit clock as the `ws` change. Bit positions after the 16 data bits are 0.
- R7: With `cfg_align`=2 (right-justified), the 16 data bits fill the last 16 positions of the slot. With `cfg_sign_fill`=0, the leading `SLOT_BITS-16` positions are 0.
- R8: With `cfg_align`=2 and `cfg_sign_fill`=1, the leading positions carry data bit 15. In the other alignments `cfg_sign_fill` is ignored.
- R9: With `cfg_lsb_first`=0, a slot sends data bit 15 first. With 1, it sends bit 0 first.
- R10: With `cfg_bclk_neg`=1, the bit clock is inverted: its idle and inactive level is high and its active edge is falling.
- R11: `cfg_chan` selects what goes in the slots: 0 sends the left sample in the left slot and the right sample in the right slot; 1 sends the right sample in both slots; 2 sends the left sample in both; 3 sends zeros in both while `bclk` and `ws` keep running.
- R12: One pair is buffered. `s_ready` is high exactly when the buffer is empty, and a pair is accepted on a cycle with `s_valid` and `s_ready` both high. The buffered pair is consumed at the first data bit of each frame. If no pair is buffered then, the frame carries zeros.
- R13: Configuration inputs are captured by `start`. Changing them while running has no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins output and captures the configuration |
| out_en | input | 1 | Output enable; low stops and idles the stream |
| cfg_align | input | 2 | Frame alignment: 0 I2S, 1 left-justified, 2 right-justified, 3 reserved (acts as I2S) |
| cfg_chan | input | 2 | Channel mode: 0 stereo, 1 mono right, 2 mono left, 3 mute |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first |
| cfg_ws_left_high | input | 1 | 1 means word select high marks the left slot |
| cfg_bclk_neg | input | 1 | 1 inverts the bit clock |
| cfg_sign_fill | input | 1 | Sign fill of spare bits in right-justified slots |
| s_valid | input | 1 | Sample pair valid |
| s_left | input | SAMPLE_W | Left sample |
| s_right | input | SAMPLE_W | Right sample |
| s_ready | output | 1 | Pair buffer empty |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select |
| sdo | output | 1 | Serial data |

## Verification
The bench uses `SAMPLE_W`=16, `SLOT_BITS`=18 and `CLK_DIV`=2. The two spare bits per slot make both the trailing zeros of the I2S and left-justified alignments and the leading zero or sign fill of the right-justified alignment observable. A bit clock of four system clocks keeps a three-frame run to a few hundred cycles, so every alignment, bit order, polarity and channel mode fits in its own short run. The same short period also lets the bench exercise an underrun frame and a configuration change in the middle of a stream.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  typedef enum logic [1:0] {
    ALIGN_I2S   = 2'd0,
    ALIGN_LEFT  = 2'd1,
    ALIGN_RIGHT = 2'd2,
    ALIGN_RSVD  = 2'd3
  } align_e;

  typedef enum logic [1:0] {
    CHAN_STEREO = 2'd0,
    CHAN_MONO_R = 2'd1,
    CHAN_MONO_L = 2'd2,
    CHAN_MUTE   = 2'd3
  } chan_e;

  typedef struct packed {
    align_e align;
    chan_e  chan;
    logic   lsb_first;
    logic   ws_left_high;
    logic   bclk_neg;
    logic   sign_fill;
  } ser_cfg_t;

endpackage

// File: rtl/aud_bclk_div.sv
// Bit clock phase counter: one falling and one rising tick per bit period.
module aud_bclk_div #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int PERIOD = 2 * CLK_DIV;
  localparam int DW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      div_q <= '0;
    end else if (div_q == DW'(PERIOD - 1)) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign fall_tick = run && (div_q == '0);
  assign rise_tick = run && (div_q == DW'(CLK_DIV));
endmodule

// File: rtl/aud_frame_pos.sv
// Bit position inside the frame, and the slot/bit that the next tick carries.
module aud_frame_pos #(
  parameter int SLOT_BITS = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic adv,
  input  logic i2s,
  output logic ws_right_n,
  output logic dat_right_n,
  output logic [$clog2(SLOT_BITS)-1:0] dat_idx_n,
  output logic head_n
);
  localparam int FRAME = 2 * SLOT_BITS;
  localparam int PW    = $clog2(FRAME);
  localparam int KW    = $clog2(SLOT_BITS);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] nxt;
  logic [PW-1:0] dpos;

  always_comb begin
    nxt = (pos_q == PW'(FRAME - 1)) ? '0 : pos_q + 1'b1;
    // I2S data trails word select by one bit clock
    if (!i2s) begin
      dpos = nxt;
    end else if (nxt == '0) begin
      dpos = PW'(FRAME - 1);
    end else begin
      dpos = nxt - 1'b1;
    end
    ws_right_n  = (nxt >= PW'(SLOT_BITS));
    dat_right_n = (dpos >= PW'(SLOT_BITS));
    dat_idx_n   = dat_right_n ? KW'(dpos - PW'(SLOT_BITS)) : KW'(dpos);
    head_n      = (dpos == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (load) begin
      pos_q <= PW'(FRAME - 1);
    end else if (adv) begin
      pos_q <= nxt;
    end
  end
endmodule

// File: rtl/aud_pair_buf.sv
// One-deep sample pair buffer with channel mode routing.
module aud_pair_buf
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                s_ready,
  input  logic                take,
  input  chan_e               chan,
  output logic [SAMPLE_W-1:0] word_l,
  output logic [SAMPLE_W-1:0] word_r
);
  logic                full_q;
  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic [SAMPLE_W-1:0] avail_l;
  logic [SAMPLE_W-1:0] avail_r;
  logic                accept;

  assign s_ready = !full_q;
  assign accept  = s_valid && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (accept) begin
      left_q  <= s_left;
      right_q <= s_right;
    end
  end

  always_comb begin
    avail_l = full_q ? left_q  : '0;
    avail_r = full_q ? right_q : '0;
    unique case (chan)
      CHAN_STEREO: begin word_l = avail_l; word_r = avail_r; end
      CHAN_MONO_R: begin word_l = avail_r; word_r = avail_r; end
      CHAN_MONO_L: begin word_l = avail_l; word_r = avail_l; end
      default:     begin word_l = '0;      word_r = '0;      end
    endcase
  end
endmodule

// File: rtl/aud_bit_pick.sv
// Selects the serial bit for a slot position from the slot word.
module aud_bit_pick #(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_BITS = 18
) (
  input  logic [SAMPLE_W-1:0]          word,
  input  logic [$clog2(SLOT_BITS)-1:0] idx,
  input  logic                         rj,
  input  logic                         lsb_first,
  input  logic                         sign_fill,
  output logic                         bit_o
);
  localparam int KW  = $clog2(SLOT_BITS);
  localparam int PAD = SLOT_BITS - SAMPLE_W;

  logic          pad_zone;
  logic          tail_zone;
  logic [KW-1:0] rel;
  logic [KW-1:0] sel;
  logic          data_bit;

  generate
    if (PAD > 0) begin : g_pad
      assign pad_zone  = rj && (idx < KW'(PAD));
      assign tail_zone = !rj && (idx >= KW'(SAMPLE_W));
      assign rel       = rj ? (idx - KW'(PAD)) : idx;
    end else begin : g_nopad
      assign pad_zone  = 1'b0;
      assign tail_zone = 1'b0;
      assign rel       = idx;
    end
  endgenerate

  always_comb begin
    sel      = lsb_first ? rel : (KW'(SAMPLE_W - 1) - rel);
    data_bit = 1'b0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (KW'(i) == sel) data_bit = word[i];
    end
    if (pad_zone) begin
      bit_o = sign_fill & word[SAMPLE_W-1];
    end else if (tail_zone) begin
      bit_o = 1'b0;
    end else begin
      bit_o = data_bit;
    end
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import aud_ser_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int SLOT_BITS = 18,
  parameter int CLK_DIV   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                out_en,
  input  logic [1:0]          cfg_align,
  input  logic [1:0]          cfg_chan,
  input  logic                cfg_lsb_first,
  input  logic                cfg_ws_left_high,
  input  logic                cfg_bclk_neg,
  input  logic                cfg_sign_fill,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                s_ready,
  output logic                bclk,
  output logic                ws,
  output logic                sdo
);
  localparam int KW = $clog2(SLOT_BITS);

  ser_cfg_t            cfg_in;
  ser_cfg_t            cfg_q;
  logic                run_q;
  logic                run_act;
  logic                start_ok;
  logic                fall_tick;
  logic                rise_tick;
  logic                ws_right_n;
  logic                dat_right_n;
  logic [KW-1:0]       dat_idx_n;
  logic                head_n;
  logic                take;
  logic                i2s;
  logic                rj;
  logic [SAMPLE_W-1:0] buf_l;
  logic [SAMPLE_W-1:0] buf_r;
  logic [SAMPLE_W-1:0] cur_l;
  logic [SAMPLE_W-1:0] cur_r;
  logic [SAMPLE_W-1:0] word_n;
  logic                bit_n;
  logic                ws_n;
  logic                bclk_q;
  logic                ws_q;
  logic                sdo_q;

  always_comb begin
    cfg_in.align        = align_e'(cfg_align);
    cfg_in.chan         = chan_e'(cfg_chan);
    cfg_in.lsb_first    = cfg_lsb_first;
    cfg_in.ws_left_high = cfg_ws_left_high;
    cfg_in.bclk_neg     = cfg_bclk_neg;
    cfg_in.sign_fill    = cfg_sign_fill;
  end

  assign run_act  = run_q && out_en;
  assign start_ok = start && out_en && !run_q;
  assign i2s      = (cfg_q.align == ALIGN_I2S) || (cfg_q.align == ALIGN_RSVD);
  assign rj       = (cfg_q.align == ALIGN_RIGHT);
  assign take     = fall_tick && head_n;

  aud_bclk_div #(.CLK_DIV(CLK_DIV)) u_div (
    .clk       (clk),
    .rst       (rst),
    .run       (run_act),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );

  aud_frame_pos #(.SLOT_BITS(SLOT_BITS)) u_pos (
    .clk         (clk),
    .rst         (rst),
    .load        (start_ok),
    .adv         (fall_tick),
    .i2s         (i2s),
    .ws_right_n  (ws_right_n),
    .dat_right_n (dat_right_n),
    .dat_idx_n   (dat_idx_n),
    .head_n      (head_n)
  );

  aud_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_left  (s_left),
    .s_right (s_right),
    .s_ready (s_ready),
    .take    (take),
    .chan    (cfg_q.chan),
    .word_l  (buf_l),
    .word_r  (buf_r)
  );

  always_comb begin
    if (dat_right_n) begin
      word_n = take ? buf_r : cur_r;
    end else begin
      word_n = take ? buf_l : cur_l;
    end
    ws_n = ws_right_n ? !cfg_q.ws_left_high : cfg_q.ws_left_high;
  end

  aud_bit_pick #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_pick (
    .word      (word_n),
    .idx       (dat_idx_n),
    .rj        (rj),
    .lsb_first (cfg_q.lsb_first),
    .sign_fill (cfg_q.sign_fill),
    .bit_o     (bit_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cfg_q  <= '0;
      cur_l  <= '0;
      cur_r  <= '0;
      bclk_q <= 1'b0;
      ws_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (!out_en) begin
      run_q  <= 1'b0;
      bclk_q <= cfg_q.bclk_neg;
      ws_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else if (start_ok) begin
      run_q  <= 1'b1;
      cfg_q  <= cfg_in;
      cur_l  <= '0;
      cur_r  <= '0;
      bclk_q <= cfg_in.bclk_neg;
    end else if (run_q) begin
      if (fall_tick) begin
        bclk_q <= cfg_q.bclk_neg;
        ws_q   <= ws_n;
        sdo_q  <= bit_n;
        if (take) begin
          cur_l <= buf_l;
          cur_r <= buf_r;
        end
      end else if (rise_tick) begin
        bclk_q <= !cfg_q.bclk_neg;
      end
    end
  end

  assign bclk = bclk_q;
  assign ws   = ws_q;
  assign sdo  = sdo_q;
endmodule

// File: rtl/aud_ser_chk.sv
module aud_ser_chk (
  input logic clk,
  input logic rst,
  input logic out_en,
  input logic s_valid,
  input logic s_ready,
  input logic bclk,
  input logic ws,
  input logic sdo,
  input logic run_q,
  input logic mute_q,
  input logic neg_q
);
  // R12
  accept_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  // R2
  disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> (sdo == 1'b0));

  // R11
  mute_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && mute_q) |-> (sdo == 1'b0));

  // R3
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && (ws != $past(ws))) |-> (bclk == neg_q));

  // R3
  sdo_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && (sdo != $past(sdo))) |-> (bclk == neg_q));

  // R10
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (bclk == neg_q));
endmodule

bind audio_ser_tx aud_ser_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .out_en  (out_en),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .bclk    (bclk),
  .ws      (ws),
  .sdo     (sdo),
  .run_q   (run_q),
  .mute_q  (cfg_q.chan == aud_ser_pkg::CHAN_MUTE),
  .neg_q   (cfg_q.bclk_neg)
);

// File: tb/test_audio_ser_tx.sv
`timescale 1ns/1ps
module test_audio_ser_tx;
  localparam int SW    = 16;
  localparam int SLOT  = 18;
  localparam int DIV   = 2;
  localparam int FRAME = 2 * SLOT;
  localparam int PAD   = SLOT - SW;
  localparam int NF    = 3;

  typedef struct packed { logic ws; logic sd; } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, out_en = 1'b0;
  logic [1:0] cfg_align = '0, cfg_chan = '0;
  logic cfg_lsb_first = 0, cfg_ws_left_high = 0, cfg_bclk_neg = 0, cfg_sign_fill = 0;
  logic s_valid = 1'b0;
  logic [SW-1:0] s_left = '0, s_right = '0;
  logic s_ready, bclk, ws, sdo;

  int nchk = 0, nfail = 0;
  longint cyc = 0;
  exp_t q[$];
  string cur_tag = "";
  logic mon_neg = 1'b0;
  logic prev_lg = 1'b0;
  bit first_pop = 1'b1;
  longint last_t = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_ser_tx #(.SAMPLE_W(SW), .SLOT_BITS(SLOT), .CLK_DIV(DIV)) i_audio_ser_tx (
    .clk(clk), .rst(rst), .start(start), .out_en(out_en),
    .cfg_align(cfg_align), .cfg_chan(cfg_chan), .cfg_lsb_first(cfg_lsb_first),
    .cfg_ws_left_high(cfg_ws_left_high), .cfg_bclk_neg(cfg_bclk_neg),
    .cfg_sign_fill(cfg_sign_fill), .s_valid(s_valid), .s_left(s_left),
    .s_right(s_right), .s_ready(s_ready), .bclk(bclk), .ws(ws), .sdo(sdo));

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, expv, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops one expected bit at each active bit clock edge
  always @(negedge clk) begin
    logic lg;
    exp_t e;
    lg = bclk ^ mon_neg;
    if (lg && !prev_lg && q.size() > 0) begin
      e = q.pop_front();
      chk(ws == e.ws, {cur_tag, " ws"}, ws, e.ws);
      chk(sdo == e.sd, {cur_tag, " sdo"}, sdo, e.sd);
      if (!first_pop) chk(cyc - last_t == 2 * DIV, "R3 bit period", cyc - last_t, 2 * DIV);
      first_pop = 1'b0;
      last_t = cyc;
    end
    prev_lg = lg;
  end

  function automatic logic exp_bit(input logic [SW-1:0] w, input int k, input int al,
                                   input logic lsb, input logic sf);
    int j;
    if (al == 2) begin
      if (k < PAD) return sf & w[SW-1];
      j = k - PAD;
    end else begin
      if (k >= SW) return 1'b0;
      j = k;
    end
    return lsb ? w[j] : w[SW-1-j];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; out_en = 1'b0; start = 1'b0; s_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic push_pair(input logic [SW-1:0] l, input logic [SW-1:0] r);
    do @(negedge clk); while (!s_ready);
    s_valid = 1'b1; s_left = l; s_right = r;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input string tag, input int al, input int ch, input logic lsb,
                          input logic lh, input logic neg, input logic sf,
                          input logic [SW-1:0] lw[NF], input logic [SW-1:0] rw[NF],
                          input int nfeed, input bit twist);
    logic [SW-1:0] fl[NF];
    logic [SW-1:0] fr[NF];
    logic dstream[NF*FRAME];
    int guard;
    int toggles;
    logic pb;
    mon_neg = neg;
    do_reset();
    cfg_align = 2'(al); cfg_chan = 2'(ch); cfg_lsb_first = lsb;
    cfg_ws_left_high = lh; cfg_bclk_neg = neg; cfg_sign_fill = sf;
    out_en = 1'b1;
    cur_tag = tag;
    first_pop = 1'b1;
    for (int f = 0; f < NF; f++) begin
      logic [SW-1:0] l, r;
      l = (f < nfeed) ? lw[f] : '0;
      r = (f < nfeed) ? rw[f] : '0;
      case (ch)
        0: begin fl[f] = l;  fr[f] = r;  end
        1: begin fl[f] = r;  fr[f] = r;  end
        2: begin fl[f] = l;  fr[f] = l;  end
        default: begin fl[f] = '0; fr[f] = '0; end
      endcase
    end
    for (int g = 0; g < NF * FRAME; g++) begin
      int d, f, k;
      f = g / FRAME; d = g % FRAME;
      k = (d >= SLOT) ? d - SLOT : d;
      dstream[g] = exp_bit((d >= SLOT) ? fr[f] : fl[f], k, al, lsb, sf);
    end
    for (int g = 0; g < NF * FRAME; g++) begin
      exp_t e;
      e.ws = ((g % FRAME) >= SLOT) ? !lh : lh;
      if (al == 0) e.sd = (g == 0) ? 1'b0 : dstream[g-1];
      else         e.sd = dstream[g];
      q.push_back(e);
    end
    push_pair(lw[0], rw[0]);
    chk(s_ready == 1'b0, "R12 buffer full after accept", s_ready, 0);
    pulse_start();
    if (twist) begin
      cfg_align = 2'd2; cfg_lsb_first = !lsb; cfg_chan = 2'd3;
      cfg_ws_left_high = !lh; cfg_sign_fill = 1'b1;
    end
    for (int f = 1; f < nfeed; f++) push_pair(lw[f], rw[f]);
    guard = 0;
    while (q.size() > 0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    chk(q.size() == 0, {tag, " stream complete"}, q.size(), 0);
    q.delete();
    // R2: disabling stops the stream
    out_en = 1'b0;
    @(negedge clk);
    chk(sdo == 1'b0, "R2 sdo after disable", sdo, 0);
    chk(bclk == neg, "R2 bclk idle after disable", bclk, neg);
    toggles = 0; pb = bclk;
    repeat (40) begin
      @(negedge clk);
      if (bclk != pb) toggles++;
      pb = bclk;
    end
    chk(toggles == 0, "R2 no bclk edges after disable", toggles, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    int toggles;
    logic pb;
    do_reset();
    // R1
    chk(bclk == 1'b0, "R1 bclk reset", bclk, 0);
    chk(ws == 1'b0, "R1 ws reset", ws, 0);
    chk(sdo == 1'b0, "R1 sdo reset", sdo, 0);
    chk(s_ready == 1'b1, "R1 s_ready reset", s_ready, 1);

    // R5 I2S, MSB first, word select low = left
    run_case("R5 i2s", 0, 0, 0, 0, 0, 0, '{16'hA5C3, 16'h8001, 16'h7FFE},
             '{16'h3C5A, 16'h0FF0, 16'h1234}, NF, 0);
    // R6 R9 R4 left-justified, LSB first, word select high = left
    run_case("R6 R9 R4 left lsb", 1, 0, 1, 1, 0, 0, '{16'hA5C3, 16'h8001, 16'h7FFE},
             '{16'h3C5A, 16'h0FF0, 16'h1234}, NF, 0);
    // R7 right-justified zero fill with negative samples
    run_case("R7 right unsigned", 2, 0, 0, 0, 0, 0, '{16'hF00F, 16'h8001, 16'h7FFE},
             '{16'h9ABC, 16'h0FF0, 16'hC000}, NF, 0);
    // R8 right-justified sign fill
    run_case("R8 right signed", 2, 0, 0, 0, 0, 1, '{16'hF00F, 16'h8001, 16'h7FFE},
             '{16'h9ABC, 16'h0FF0, 16'hC000}, NF, 0);
    // R8 sign fill ignored outside right-justified
    run_case("R8 sign ignored left", 1, 0, 0, 0, 0, 1, '{16'hF00F, 16'h8001, 16'hFFFF},
             '{16'h9ABC, 16'hFFFF, 16'hC000}, NF, 0);
    // R9 right-justified LSB first
    run_case("R9 right lsb", 2, 0, 1, 1, 0, 1, '{16'h8003, 16'h4001, 16'h7FFE},
             '{16'h9ABC, 16'h0FF0, 16'hC000}, NF, 0);
    // R10 R3 inverted bit clock
    run_case("R10 inverted bclk", 0, 0, 0, 0, 1, 0, '{16'hA5C3, 16'h8001, 16'h7FFE},
             '{16'h3C5A, 16'h0FF0, 16'h1234}, NF, 0);
    // R11 channel modes
    run_case("R11 mono right", 0, 1, 0, 0, 0, 0, '{16'hA5C3, 16'h8001, 16'h7FFE},
             '{16'h3C5A, 16'h0FF0, 16'h1234}, NF, 0);
    run_case("R11 mono left", 1, 2, 0, 0, 0, 0, '{16'hA5C3, 16'h8001, 16'h7FFE},
             '{16'h3C5A, 16'h0FF0, 16'h1234}, NF, 0);
    run_case("R11 mute", 0, 3, 0, 1, 0, 0, '{16'hFFFF, 16'h8001, 16'h7FFE},
             '{16'hFFFF, 16'h0FF0, 16'h1234}, NF, 0);
    // R13 configuration changes after start are ignored
    run_case("R13 captured cfg", 1, 0, 0, 0, 0, 0, '{16'hA5C3, 16'h8001, 16'h7FFE},
             '{16'h3C5A, 16'h0FF0, 16'h1234}, NF, 1);
    // R12 underrun sends zeros
    run_case("R12 underrun", 1, 0, 0, 0, 0, 0, '{16'hFFFF, 16'hFFFF, 16'hFFFF},
             '{16'hFFFF, 16'hFFFF, 16'hFFFF}, 1, 0);

    // R2 start ignored while disabled
    mon_neg = 1'b0;
    do_reset();
    out_en = 1'b0;
    push_pair(16'hAAAA, 16'h5555);
    pulse_start();
    toggles = 0; pb = bclk;
    repeat (60) begin
      @(negedge clk);
      if (bclk != pb) toggles++;
      pb = bclk;
      if (sdo != 1'b0) toggles++;
    end
    chk(toggles == 0, "R2 start ignored when disabled", toggles, 0);
    chk(s_ready == 1'b0, "R2 pair not consumed when disabled", s_ready, 0);

    done = 1'b1;
    summary();
  end
endmodule